// File: doc/BRIEF.md
# Transmit Queue Credit Tracker

This block decides whether a transmit packet may be handed to one chip-internal queue. It keeps a running total of the bytes and packets that are outstanding. A packet counts as outstanding from the moment it is admitted until a transmit-status notification comes back for it. A requester presents a length together with a one-cycle request pulse. In the same cycle the block answers with either grant or deny.

A grant requires three things. The queue must not be suspended. The outstanding packet count must be below a fixed cap. The outstanding bytes plus the new length must fit in the usable byte budget, which is the reported buffer size less a fixed overhead. Admitted lengths are kept in an in-order FIFO. Each status strobe therefore returns exactly the credit of the oldest outstanding packet.

Top module: `tx_credit_gate`

## Requirements
- R1: The usable byte budget is `buf_size - 80`. When `buf_size` is 80 or less the budget is 0. The budget follows `buf_size` in the same cycle.
- R2: A request is granted only if the outstanding bytes plus `req_len` are less than or equal to the usable byte budget. A length that exactly fills the budget is granted.
- R3: No more than 31 packets are ever outstanding. With 31 outstanding and no release in that cycle, a request is denied.
- R4: On the clock edge after a grant, `out_pkts` rises by one and `out_bytes` rises by the granted length. Counters change only on a grant or a status return.
- R5: While `suspend` is 1, every request is denied. A status return in that cycle is still applied.
- R6: Each `status_ret` with packets outstanding lowers `out_pkts` by one. It also lowers `out_bytes` by the length of the oldest packet still outstanding, in admission order.
- R7: A request in the same cycle as a status return is judged against the counters after that release.
- R8: A `status_ret` with nothing outstanding leaves the counters unchanged. It sets `underflow` on the next edge, and `underflow` stays set until reset.
- R9: In a cycle with `req_valid` high, exactly one of `grant` and `deny` is 1. With `req_valid` low, both are 0.
- R10: After reset, `out_bytes`, `out_pkts` and `underflow` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_size | input | SIZE_W | Reported internal buffer size in bytes |
| suspend | input | 1 | Queue suspended; all requests are denied |
| req_valid | input | 1 | Admission request pulse |
| req_len | input | LEN_W | Length of the requested packet in bytes |
| status_ret | input | 1 | Transmit-status notification for the oldest packet |
| grant | output | 1 | Request admitted (same cycle) |
| deny | output | 1 | Request refused (same cycle) |
| out_bytes | output | SIZE_W | Outstanding bytes |
| out_pkts | output | CNT_W | Outstanding packets |
| underflow | output | 1 | Sticky: a status arrived with nothing outstanding |

## Verification
A wrong FIFO pointer or a stale length entry shows up on `out_bytes` on the edge after the status strobe. The bench releases packets of distinct lengths one at a time, so a mismatch appears within one cycle of the faulty release. A wrong comparison or a wrong overhead shows up as a grant or deny of the wrong polarity in the same cycle as the request. The bench sweeps lengths and buffer sizes across each boundary, which exposes an off-by-one at the exact edge. A miscounted packet total surfaces at the 31-packet cap and at the point where a release and a request coincide.

// File: rtl/tx_credit_gate.sv
module tx_credit_gate #(
  parameter int SIZE_W   = 16,
  parameter int LEN_W    = 12,
  parameter int MAX_PKTS = 31,
  parameter int OVERHEAD = 80,
  localparam int CNT_W   = $clog2(MAX_PKTS + 1),
  localparam int PTR_W   = $clog2(MAX_PKTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] buf_size,
  input  logic              suspend,
  input  logic              req_valid,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              status_ret,
  output logic              grant,
  output logic              deny,
  output logic [SIZE_W-1:0] out_bytes,
  output logic [CNT_W-1:0]  out_pkts,
  output logic              underflow
);

  logic [LEN_W-1:0]  lens [MAX_PKTS];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [SIZE_W-1:0] budget, rel_bytes;
  logic [CNT_W-1:0]  rel_pkts;
  logic              release_ok, fits, room;

  assign budget     = (buf_size > SIZE_W'(OVERHEAD)) ? buf_size - SIZE_W'(OVERHEAD) : '0;
  assign release_ok = status_ret && (out_pkts != '0);
  assign rel_bytes  = release_ok ? out_bytes - SIZE_W'(lens[rd_ptr]) : out_bytes;
  assign rel_pkts   = release_ok ? out_pkts - 1'b1 : out_pkts;
  assign fits       = ({1'b0, rel_bytes} + (SIZE_W+1)'(req_len)) <= {1'b0, budget};
  assign room       = rel_pkts < CNT_W'(MAX_PKTS);
  assign grant      = req_valid && !suspend && fits && room;
  assign deny       = req_valid && !grant;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(MAX_PKTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_bytes <= '0;
      out_pkts  <= '0;
      underflow <= 1'b0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
    end else begin
      out_bytes <= grant ? rel_bytes + SIZE_W'(req_len) : rel_bytes;
      out_pkts  <= grant ? rel_pkts + 1'b1 : rel_pkts;
      if (status_ret && out_pkts == '0) underflow <= 1'b1;
      if (release_ok) rd_ptr <= bump(rd_ptr);
      if (grant)      wr_ptr <= bump(wr_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (grant) lens[wr_ptr] <= req_len;
  end

endmodule

module tx_credit_gate_chk #(
  parameter int SIZE_W   = 16,
  parameter int LEN_W    = 12,
  parameter int MAX_PKTS = 31,
  parameter int OVERHEAD = 80,
  localparam int CNT_W   = $clog2(MAX_PKTS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SIZE_W-1:0] buf_size,
  input logic              suspend,
  input logic              req_valid,
  input logic [LEN_W-1:0]  req_len,
  input logic              status_ret,
  input logic              grant,
  input logic              deny,
  input logic [SIZE_W-1:0] out_bytes,
  input logic [CNT_W-1:0]  out_pkts,
  input logic              underflow
);
  logic [SIZE_W:0] lim;
  assign lim = ({1'b0, buf_size} > (SIZE_W+1)'(OVERHEAD)) ? {1'b0, buf_size} - (SIZE_W+1)'(OVERHEAD) : '0;

  p_pkt_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_pkts <= CNT_W'(MAX_PKTS));
  p_grant_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> ({1'b0, out_bytes} <= $past(lim)));
  p_suspend_deny_r5: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> !grant);
  p_one_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny) && ((grant || deny) == req_valid));
  p_underflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && !status_ret) |=> ($stable(out_bytes) && $stable(out_pkts)));
  p_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !status_ret) |=> (out_pkts == $past(out_pkts) + 1'b1));
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_ret && !grant && out_pkts != '0) |=> (out_pkts == $past(out_pkts) - 1'b1));
endmodule

bind tx_credit_gate tx_credit_gate_chk #(
  .SIZE_W(SIZE_W), .LEN_W(LEN_W), .MAX_PKTS(MAX_PKTS), .OVERHEAD(OVERHEAD)
) u_chk (.*);

// File: tb/tx_credit_gate_test.sv
module tx_credit_gate_test;
  logic        clk = 0, rst_n = 0;
  logic [15:0] buf_size = 0;
  logic        suspend = 0, req_valid = 0, status_ret = 0;
  logic [11:0] req_len = 0;
  logic        grant, deny, underflow;
  logic [15:0] out_bytes;
  logic [4:0]  out_pkts;

  int checks = 0, fails = 0;
  int mq [0:63];
  int mh = 0, mt = 0, mn = 0, mb = 0;
  bit muf = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tx_credit_gate uut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit rq, int len, bit rt);
    int budget, rb, rp, hd;
    bit eff, ok;
    @(negedge clk);
    req_valid = rq; req_len = 12'(len); status_ret = rt;
    #1;
    budget = (int'(buf_size) > 80) ? int'(buf_size) - 80 : 0;
    eff = rt && mn > 0;
    hd  = eff ? mq[mh] : 0;
    rb  = mb - hd;
    rp  = mn - (eff ? 1 : 0);
    ok  = !suspend && rp < 31 && (rb + len) <= budget;
    chk({tag, " grant"}, int'(grant), int'(rq && ok));
    chk("R9 deny", int'(deny), int'(rq && !ok));
    @(posedge clk);
    if (rt && mn == 0) muf = 1;
    if (eff) begin mh = (mh + 1) % 64; mn--; mb -= hd; end
    if (rq && ok) begin mq[mt] = len; mt = (mt + 1) % 64; mn++; mb += len; end
    #1;
    req_valid = 0; status_ret = 0;
    chk("R4 R6 out_bytes", int'(out_bytes), mb);
    chk("R4 R6 out_pkts", int'(out_pkts), mn);
    chk("R8 underflow", int'(underflow), int'(muf));
  endtask

  task automatic drain();
    while (mn > 0) step("R6", 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 out_bytes", int'(out_bytes), 0);
    chk("R10 out_pkts", int'(out_pkts), 0);
    chk("R10 underflow", int'(underflow), 0);
    rst_n = 1;

    buf_size = 16'd4000;
    step("R8", 0, 0, 1);
    step("R8", 1, 10, 0);
    drain();

    for (int i = 0; i < 33; i++) step("R3", 1, 1, 0);
    step("R7", 1, 5, 1);
    step("R3", 1, 1, 0);
    drain();

    for (int i = 0; i < 20; i++) step("R4", 1, i * 7 + 3, 0);
    for (int i = 0; i < 10; i++) step("R7", 1, i * 11 + 1, 1);
    drain();

    buf_size = 16'd280;
    step("R2", 1, 100, 0);
    for (int l = 0; l <= 140; l++) begin
      step("R2", 1, l, 0);
      if (mn > 1) step("R2", 0, 0, 0);
      while (mn > 1) begin
        step("R6", 0, 0, 1);
        step("R6", 0, 0, 1);
        step("R2", 1, 100, 0);
      end
    end
    drain();
    step("R2", 1, 200, 0);
    step("R2", 1, 0, 0);
    step("R2", 1, 1, 0);
    step("R7", 1, 150, 1);
    drain();

    for (int b = 60; b <= 100; b++) begin
      buf_size = 16'(b);
      step("R1", 1, 1, 0);
      step("R1", 1, 0, 0);
      drain();
    end
    buf_size = 16'd100;
    step("R1", 1, 20, 0);
    buf_size = 16'd99;
    step("R1", 1, 0, 0);
    drain();

    buf_size = 16'd2000;
    step("R5", 1, 30, 0);
    step("R5", 1, 40, 0);
    suspend = 1;
    step("R5", 1, 1, 0);
    step("R5", 1, 0, 1);
    step("R5", 1, 5, 0);
    suspend = 0;
    step("R5", 1, 5, 0);
    drain();
    step("R8", 0, 0, 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule